// File: doc/BRIEF.md
# Dual-Lane I2S Four-Channel Receiver

This block takes two I2S serial data lanes, one for the front speaker pair and one for the rear pair. Both lanes share a single word-select line and a single continuous bit clock. Every register in the block runs on that bit clock. Each lane is turned into a left word and a right word, 18 bits each. Once per stereo frame, all four words are presented together on parallel outputs, with a one-cycle valid strobe.

Downstream logic waits for the strobe and then takes front-left, front-right, rear-left and rear-right as one aligned set. The word length is fixed at 18 bits. A longer word is cut down to its 18 most significant bits. A shorter word has zeros added below its last received bit.

Top module: `i2s_quad_rx`

## Requirements
- R1: A word sent while `word_sel` is 0 is a left word and appears on `front_left`/`rear_left`. A word sent while `word_sel` is 1 is a right word and appears on `front_right`/`rear_right`.
- R2: Bits are sampled on the rising edge of `bclk`, most significant bit first. The MSB of a word is the bit sampled one edge after the edge that first sees the new `word_sel` level.
- R3: Both lanes are captured in lockstep under the same `word_sel`. The `sd_front` lane feeds the two front outputs and the `sd_rear` lane feeds the two rear outputs.
- R4: When a word carries more than 18 bits, only the first 18 bits received are kept and the remaining bits are ignored.
- R5: When a word carries fewer than 18 bits, the received bits fill the word from bit 17 downward and every lower bit is 0.
- R6: The four outputs change only in a cycle where `frame_vld` is high. Otherwise they hold their values.
- R7: `frame_vld` is high for exactly one cycle. It starts at the rising edge that samples the MSB of the left word following a right word. It is raised only if that right word and the left word before it both began at a `word_sel` transition seen since reset.
- R8: While `rst_n` is low, all outputs are 0 and `frame_vld` is 0. After reset, no frame is presented until one complete left word and one complete right word have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Continuous serial bit clock; clocks the whole block |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| word_sel | input | 1 | Shared channel select: 0 for left, 1 for right |
| sd_front | input | 1 | Serial data of the front lane |
| sd_rear | input | 1 | Serial data of the rear lane |
| front_left | output | 18 | Front-lane left sample |
| front_right | output | 18 | Front-lane right sample |
| rear_left | output | 18 | Rear-lane left sample |
| rear_right | output | 18 | Rear-lane right sample |
| frame_vld | output | 1 | One-cycle strobe when all four samples update |

## Verification
A wrong bit position or a mishandled bit counter in either lane shows up as wrong bits in the next published frame. That is at most one stereo frame after the word that was damaged. A wrong `word_sel` history shows up earlier, as a strobe in the wrong cycle or as left and right words swapped. A lost record of the held left word shows up as a frame that never arrives. The bench runs a behavioural model that tracks every edge and compares all outputs in every cycle, so any of these faults is caught in the cycle it first appears.

// File: rtl/i2s_quad_pkg.sv
package i2s_quad_pkg;

  // Default sample width of every channel word
  localparam int unsigned SAMPLE_W = 18;

  // Number of serial data lanes (front, rear)
  localparam int unsigned LANES = 2;

  // Channel carried by a word, as encoded on the word-select line
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/i2s_rst_sync.sv
module i2s_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_n;
    end
  end

  assign rst_n_o = sr_q[STAGES-1];

endmodule

// File: rtl/i2s_ws_track.sv
module i2s_ws_track
  import i2s_quad_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_sel,
  output logic  word_start,  // this edge samples the MSB of a new word
  output chan_e done_chan,   // channel of the word that just ended
  output logic  prev_whole   // the word that just ended began at a transition
);

  logic ws_q, ws_qq, synced_q;
  logic ws_n, ws_nn, synced_n;

  assign word_start = ws_q ^ ws_qq;
  assign done_chan  = chan_e'(ws_qq);
  assign prev_whole = synced_q;

  always_comb begin
    ws_n     = word_sel;
    ws_nn    = ws_q;
    synced_n = synced_q | word_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      ws_qq    <= 1'b0;
      synced_q <= 1'b0;
    end else begin
      ws_q     <= ws_n;
      ws_qq    <= ws_nn;
      synced_q <= synced_n;
    end
  end

endmodule

// File: rtl/i2s_lane_deser.sv
module i2s_lane_deser #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              word_start,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              cnt_en;

  // Count saturates at WORD_W, so bits beyond the word width are dropped
  assign cnt_en = word_start | (cnt_q < CNT_FULL);

  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    if (word_start) begin
      shreg_n           = '0;
      shreg_n[WORD_W-1] = bit_i;
      cnt_n             = CNT_W'(1);
    end else if (cnt_q < CNT_FULL) begin
      for (int i = 0; i < int'(WORD_W); i++) begin
        if (i == int'(WORD_W) - 1 - int'(cnt_q)) begin
          shreg_n[i] = bit_i;
        end
      end
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= CNT_FULL;
    end else if (cnt_en) begin
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
    end
  end

  assign word_o = shreg_q;

endmodule

// File: rtl/i2s_frame_align.sv
module i2s_frame_align
  import i2s_quad_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_start,
  input  chan_e             done_chan,
  input  logic              prev_whole,
  input  logic [WORD_W-1:0] front_word,
  input  logic [WORD_W-1:0] rear_word,
  output logic [WORD_W-1:0] out_fl,
  output logic [WORD_W-1:0] out_fr,
  output logic [WORD_W-1:0] out_rl,
  output logic [WORD_W-1:0] out_rr,
  output logic              out_vld
);

  logic [WORD_W-1:0] hold_f_q, hold_r_q;
  logic              left_ok_q, left_ok_n;
  logic              left_en, frame_en;
  logic [WORD_W-1:0] fl_q, fr_q, rl_q, rr_q;
  logic              vld_q, vld_n;

  always_comb begin
    left_en   = word_start & prev_whole & (done_chan == CH_LEFT);
    frame_en  = word_start & prev_whole & (done_chan == CH_RIGHT) & left_ok_q;
    left_ok_n = left_ok_q | left_en;
    vld_n     = frame_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_f_q  <= '0;
      hold_r_q  <= '0;
      left_ok_q <= 1'b0;
    end else begin
      left_ok_q <= left_ok_n;
      if (left_en) begin
        hold_f_q <= front_word;
        hold_r_q <= rear_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      fr_q  <= '0;
      rl_q  <= '0;
      rr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      if (frame_en) begin
        fl_q <= hold_f_q;
        fr_q <= front_word;
        rl_q <= hold_r_q;
        rr_q <= rear_word;
      end
    end
  end

  assign out_fl  = fl_q;
  assign out_fr  = fr_q;
  assign out_rl  = rl_q;
  assign out_rr  = rr_q;
  assign out_vld = vld_q;

endmodule

// File: rtl/i2s_quad_rx.sv
module i2s_quad_rx
  import i2s_quad_pkg::*;
#(
  parameter int unsigned WORD_W = SAMPLE_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              word_sel,
  input  logic              sd_front,
  input  logic              sd_rear,
  output logic [WORD_W-1:0] front_left,
  output logic [WORD_W-1:0] front_right,
  output logic [WORD_W-1:0] rear_left,
  output logic [WORD_W-1:0] rear_right,
  output logic              frame_vld
);

  logic              core_rst_n;
  logic              word_start;
  chan_e             done_chan;
  logic              prev_whole;
  logic [LANES-1:0]  lane_bit;
  logic [WORD_W-1:0] lane_word [LANES];

  assign lane_bit = {sd_rear, sd_front};

  i2s_rst_sync #(.STAGES(2)) u_rst (
    .clk     (bclk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  i2s_ws_track u_ws (
    .clk        (bclk),
    .rst_n      (core_rst_n),
    .word_sel   (word_sel),
    .word_start (word_start),
    .done_chan  (done_chan),
    .prev_whole (prev_whole)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    i2s_lane_deser #(.WORD_W(WORD_W)) u_deser (
      .clk        (bclk),
      .rst_n      (core_rst_n),
      .bit_i      (lane_bit[g]),
      .word_start (word_start),
      .word_o     (lane_word[g])
    );
  end

  i2s_frame_align #(.WORD_W(WORD_W)) u_align (
    .clk        (bclk),
    .rst_n      (core_rst_n),
    .word_start (word_start),
    .done_chan  (done_chan),
    .prev_whole (prev_whole),
    .front_word (lane_word[0]),
    .rear_word  (lane_word[1]),
    .out_fl     (front_left),
    .out_fr     (front_right),
    .out_rl     (rear_left),
    .out_rr     (rear_right),
    .out_vld    (frame_vld)
  );

endmodule

// File: rtl/i2s_quad_rx_chk.sv
module i2s_quad_rx_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              bclk,
  input logic              rst_n,
  input logic              word_sel,
  input logic [WORD_W-1:0] front_left,
  input logic [WORD_W-1:0] front_right,
  input logic [WORD_W-1:0] rear_left,
  input logic [WORD_W-1:0] rear_right,
  input logic              frame_vld
);

  // R7
  vld_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R7
  vld_after_right_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_vld |-> ($past(word_sel, 2) == 1'b0 && $past(word_sel, 3) == 1'b1));

  // R6
  front_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_vld |-> ($stable(front_left) && $stable(front_right)));

  // R6
  rear_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_vld |-> ($stable(rear_left) && $stable(rear_right)));

endmodule

bind i2s_quad_rx i2s_quad_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .bclk        (bclk),
  .rst_n       (rst_n),
  .word_sel    (word_sel),
  .front_left  (front_left),
  .front_right (front_right),
  .rear_left   (rear_left),
  .rear_right  (rear_right),
  .frame_vld   (frame_vld)
);

// File: tb/tb_i2s_quad_rx.sv
module tb_i2s_quad_rx;

  localparam int W = 18;

  logic         bclk = 1'b0;
  logic         rst_n;
  logic         word_sel;
  logic         sd_front;
  logic         sd_rear;
  logic [W-1:0] front_left, front_right, rear_left, rear_right;
  logic         frame_vld;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 bclk = ~bclk;

  i2s_quad_rx dut (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .word_sel    (word_sel),
    .sd_front    (sd_front),
    .sd_rear     (sd_rear),
    .front_left  (front_left),
    .front_right (front_right),
    .rear_left   (rear_left),
    .rear_right  (rear_right),
    .frame_vld   (frame_vld)
  );

  // ---------------- behavioural reference model ----------------
  int           p1, p2;
  bit           started, m_left_ok;
  bit           bits_f[$];
  bit           bits_r[$];
  logic [W-1:0] m_lf, m_lr;
  logic [W-1:0] e_fl, e_fr, e_rl, e_rr;
  logic         e_vld;

  function automatic logic [W-1:0] pack_word(input bit q[$]);
    logic [W-1:0] v = '0;
    for (int i = 0; i < W; i++) begin
      if (i < q.size()) v[W-1-i] = q[i];
    end
    return v;
  endfunction

  always @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; started = 0; m_left_ok = 0;
      bits_f.delete(); bits_r.delete();
      m_lf = '0; m_lr = '0;
      e_fl = '0; e_fr = '0; e_rl = '0; e_rr = '0; e_vld = 1'b0;
    end else begin
      e_vld = 1'b0;
      if (p1 != p2) begin
        if (started) begin
          if (p2 == 0) begin
            m_lf = pack_word(bits_f);
            m_lr = pack_word(bits_r);
            m_left_ok = 1;
          end else if (m_left_ok) begin
            e_fl = m_lf; e_fr = pack_word(bits_f);
            e_rl = m_lr; e_rr = pack_word(bits_r);
            e_vld = 1'b1;
          end
        end
        started = 1;
        bits_f.delete(); bits_r.delete();
      end
      bits_f.push_back(sd_front);
      bits_r.push_back(sd_rear);
      p2 = p1;
      p1 = int'(word_sel);
    end
  end

  // ---------------- comparison and frame capture ----------------
  logic [W-1:0] got_fl[$], got_fr[$], got_rl[$], got_rr[$];

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge bclk) begin
    if (rst_n === 1'b1 && !done) begin
      check(front_left == e_fl,  "R1 front_left",  front_left,  e_fl);
      check(front_right == e_fr, "R1 front_right", front_right, e_fr);
      check(rear_left == e_rl,   "R3 rear_left",   rear_left,   e_rl);
      check(rear_right == e_rr,  "R3 rear_right",  rear_right,  e_rr);
      check(frame_vld == e_vld,  "R7 frame_vld",   W'(frame_vld), W'(e_vld));
      if (frame_vld) begin
        got_fl.push_back(front_left);  got_fr.push_back(front_right);
        got_rl.push_back(rear_left);   got_rr.push_back(rear_right);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic nxt_f, nxt_r;

  task automatic send_word(input logic chan, input logic [23:0] vf,
                           input logic [23:0] vr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bclk);
      word_sel = chan;
      sd_front = nxt_f;
      sd_rear  = nxt_r;
      nxt_f    = vf[n-1-i];
      nxt_r    = vr[n-1-i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bclk);
      sd_front = nxt_f;
      sd_rear  = nxt_r;
      nxt_f    = 1'b0;
      nxt_r    = 1'b0;
    end
  endtask

  task automatic expect_frame(input string tag, input logic [W-1:0] fl,
                              input logic [W-1:0] fr, input logic [W-1:0] rl,
                              input logic [W-1:0] rr);
    if (got_fl.size() == 0) begin
      check(1'b0, {tag, " frame missing"}, '0, W'(1));
    end else begin
      check(got_fl[0] == fl, {tag, " fl"}, got_fl[0], fl);
      check(got_fr[0] == fr, {tag, " fr"}, got_fr[0], fr);
      check(got_rl[0] == rl, {tag, " rl"}, got_rl[0], rl);
      check(got_rr[0] == rr, {tag, " rr"}, got_rr[0], rr);
      void'(got_fl.pop_front()); void'(got_fr.pop_front());
      void'(got_rl.pop_front()); void'(got_rr.pop_front());
    end
  endtask

  task automatic check_reset_outputs(input string tag);
    check(front_left == '0 && front_right == '0, {tag, " front zero"},
          front_left | front_right, '0);
    check(rear_left == '0 && rear_right == '0, {tag, " rear zero"},
          rear_left | rear_right, '0);
    check(frame_vld == 1'b0, {tag, " vld low"}, W'(frame_vld), '0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge bclk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; word_sel = 1'b0; sd_front = 1'b0; sd_rear = 1'b0;
    nxt_f = 1'b0; nxt_r = 1'b0;
    repeat (4) @(negedge bclk);
    check_reset_outputs("R8 reset");
    rst_n = 1'b1;
    idle(6);

    // Right word before any left: must not produce a frame (R8)
    send_word(1'b1, 24'h0, 24'h0, 18);
    // R2/R3: full-width frame
    send_word(1'b0, 24'h2A5A5, 24'h3C3C3, 18);
    send_word(1'b1, 24'h15A5A, 24'h00001, 18);
    // R4: 24-bit words truncated
    send_word(1'b0, 24'hABCDEF, 24'hFFFFFF, 24);
    send_word(1'b1, 24'h123456, 24'h000001, 24);
    // R5: 12-bit words zero padded
    send_word(1'b0, 24'hABC, 24'hFFF, 12);
    send_word(1'b1, 24'h801, 24'h001, 12);
    send_word(1'b0, 24'h0, 24'h0, 4);
    idle(4);

    check(got_fl.size() == 3, "R8 frame count", W'(got_fl.size()), W'(3));
    expect_frame("R2", 18'h2A5A5, 18'h15A5A, 18'h3C3C3, 18'h00001);
    expect_frame("R4", 18'h2AF37, 18'h048D1, 18'h3FFFF, 18'h00000);
    expect_frame("R5", 18'h2AF00, 18'h20040, 18'h3FFC0, 18'h00040);

    // Reset in the middle of a word
    send_word(1'b1, 24'h11111, 24'h22222, 9);
    @(negedge bclk);
    rst_n = 1'b0; word_sel = 1'b0; sd_front = 1'b0; sd_rear = 1'b0;
    nxt_f = 1'b0; nxt_r = 1'b0;
    @(negedge bclk);
    check_reset_outputs("R8 mid reset");
    word_sel = 1'b1;
    @(negedge bclk);
    rst_n = 1'b1;
    idle(4);
    got_fl.delete(); got_fr.delete(); got_rl.delete(); got_rr.delete();
    send_word(1'b1, 24'h3FFFF, 24'h3FFFF, 6);
    send_word(1'b0, 24'h0F0F0, 24'h30303, 18);
    send_word(1'b1, 24'h2D2D2, 24'h12345, 18);
    send_word(1'b0, 24'h0, 24'h0, 3);
    idle(4);
    check(got_fl.size() == 1, "R8 first frame after reset", W'(got_fl.size()), W'(1));
    expect_frame("R1", 18'h0F0F0, 18'h2D2D2, 18'h30303, 18'h12345);
    // R6: outputs held while idle
    idle(3);
    check(front_left == 18'h0F0F0 && rear_right == 18'h12345, "R6 hold",
          front_left, 18'h0F0F0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule